// File: doc/BRIEF.md
# Call and Return Stack Controller

This block carries out subroutine calls and returns for a small 8-bit core whose return stack sits in on-chip scratch RAM. The stack depth is eight frames. The stack pointer is not a separate register: it is the low three bits of the processor status word. The controller reads that pointer from the status word it is given and hands back an updated status word. Each frame is two RAM bytes. One byte holds the low half of the return address. The other byte holds the high address nibble together with the upper status flags.

A call takes two cycles. The first cycle writes the low frame byte. The second cycle writes the high frame byte, issues the new program counter and issues the status word with the pointer incremented. A return also takes two cycles. It reads the frame below the current pointer, one byte per cycle, through an asynchronous read port. It then issues the restored program counter and the status word with the pointer decremented. The plain return keeps the current flags. The restoring return reloads the upper flags from the frame.

The core drives a one-cycle strobe together with its current program counter and status word. The controller samples those values on the strobe cycle. It writes results back through the two write-enable outputs in the second cycle.

Top module: `call_stack_ctrl`

## Requirements
- R1: After a synchronous active-low reset the block is idle: busy, ram_we, ram_re, pc_we and psw_we are all 0.
- R2: The frame for pointer value n has its low byte at RAM address 0x08+2n and its high byte at 0x09+2n. Every RAM access falls within 0x08 to 0x17, and the high byte is always accessed in the cycle after the low byte.
- R3: A call first writes (pc_cur+2)[7:0]. In the next cycle it writes {psw_in[7:4], (pc_cur+2)[11:8]}, with the flags in bits 7:4 of that byte and the address nibble in bits 3:0.
- R4: In the second cycle of a call, pc_out is {pc_cur[11], call_page, call_offset} with pc_we=1. In the same cycle psw_out is psw_in with bits 2:0 incremented modulo 8 and bits 7:3 unchanged, with psw_we=1.
- R5: A plain return reads the frame at pointer-1 (modulo 8). It drives pc_out = {high[3:0], low} with pc_we=1, and psw_out = psw_in with bits 2:0 decremented and bits 7:3 unchanged, with psw_we=1.
- R6: A restoring return does the same as R5, except that psw_out[7:4] is taken from bits 7:4 of the saved high byte. Bit 3 still comes from psw_in.
- R7: The pointer wraps without a flag. A call at pointer 7 uses bytes 0x16/0x17 and yields pointer 0. A return at pointer 0 reads 0x16/0x17 and yields pointer 7.
- R8: Every operation lasts two cycles. On the strobe cycle busy=0, pc_we=0 and psw_we=0. On the next cycle busy=1, and pc_we and psw_we are 1 for that one cycle only.
- R9: Strobes raised while busy=1 are ignored. When several strobes arrive together, call wins over the restoring return, and the restoring return wins over the plain return.
- R10: pc_cur, psw_in, call_page and call_offset are sampled only on the strobe cycle. Their values during the second cycle do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_req | input | 1 | Call strobe |
| ret_req | input | 1 | Plain return strobe |
| retr_req | input | 1 | Flag-restoring return strobe |
| call_page | input | 3 | Target address bits 10:8 |
| call_offset | input | 8 | Target address bits 7:0 |
| pc_cur | input | 12 | Address of the call instruction |
| psw_in | input | 8 | Current status word, pointer in bits 2:0 |
| ram_rdata | input | 8 | Asynchronous read data for ram_addr |
| ram_addr | output | 6 | Scratch RAM byte address |
| ram_wdata | output | 8 | Scratch RAM write data |
| ram_we | output | 1 | Scratch RAM write enable |
| ram_re | output | 1 | Scratch RAM read strobe |
| pc_out | output | 12 | New program counter |
| pc_we | output | 1 | pc_out valid |
| psw_out | output | 8 | New status word |
| psw_we | output | 1 | psw_out valid |
| busy | output | 1 | Second cycle of an operation in progress |

## Verification
The assertions assume that ram_rdata reflects ram_addr in the same cycle. They also assume that the status word seen on a strobe cycle is the one the core actually holds, because the pointer checks compare psw_out with the value psw_in had one cycle earlier. The bench keeps to these assumptions in two ways: its RAM model reads combinationally, and it feeds each operation the status word the previous operation produced. It deliberately changes psw_in and pc_cur to junk during second cycles, which is legal under R10. It raises overlapping strobes only where R9 defines the outcome.

// File: rtl/cstk_pkg.sv
// Shared types for the call/return stack controller.
package cstk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PUSH_HI = 2'd1,
        ST_POP_HI  = 2'd2
    } cstk_state_e;
endpackage

// File: rtl/cstk_fsm.sv
// Sequencer: accepts one strobe when idle, then spends exactly one more
// cycle in a second state. Assumes strobes are single-cycle pulses;
// priority is call, then restoring return, then plain return.
module cstk_fsm
    import cstk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_call,
    input  logic        req_ret,
    input  logic        req_retr,
    output cstk_state_e state,
    output logic        start_push,
    output logic        start_pop,
    output logic        restore_q
);
    // Decode which operation begins this cycle.
    always_comb begin
        start_push = (state == ST_IDLE) && req_call;
        start_pop  = (state == ST_IDLE) && !req_call && (req_ret || req_retr);
    end

    // State register and return-flavour latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            restore_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_push) begin
                        state <= ST_PUSH_HI;
                    end else if (start_pop) begin
                        state     <= ST_POP_HI;
                        restore_q <= req_retr;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_PUSH_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        start_push |=> (state == ST_PUSH_HI)); // R8
    AST_POP_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        start_pop |=> (state == ST_POP_HI)); // R8
    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state == ST_IDLE)); // R9
    AST_CALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && req_call && (req_ret || req_retr)) |=> (state == ST_PUSH_HI)); // R9
endmodule

// File: rtl/cstk_addr.sv
// Frame address generator: maps a frame index and a byte select onto the
// fixed RAM window. Assumes the window fits inside the RAM address space.
module cstk_addr #(
    parameter int SP_W       = 3,
    parameter int AW         = 6,
    parameter int STACK_BASE = 8
) (
    input  logic [SP_W-1:0] idx,
    input  logic            hi_sel,
    output logic [AW-1:0]   addr
);
    // Two bytes per frame, low byte at the even offset.
    always_comb begin
        addr = AW'(STACK_BASE) + AW'({idx, 1'b0}) + AW'(hi_sel);
    end
endmodule

// File: rtl/cstk_frame.sv
// Frame datapath: captures the core's state on the strobe cycle, packs the
// push bytes, unpacks the popped frame and forms the new PC and status word.
// Assumes an asynchronous RAM read and PC_W > DW + PAGE_W.
module cstk_frame
    import cstk_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int DW     = 8,
    parameter int SP_W   = 3,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cstk_state_e       state,
    input  logic              start_push,
    input  logic              start_pop,
    input  logic              restore_q,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [PAGE_W-1:0] page,
    input  logic [DW-1:0]     offset,
    input  logic [DW-1:0]     psw_in,
    input  logic [DW-1:0]     ram_rdata,
    output logic [SP_W-1:0]   idx,
    output logic              hi_sel,
    output logic [DW-1:0]     ram_wdata,
    output logic              ram_we,
    output logic              ram_re,
    output logic [PC_W-1:0]   pc_out,
    output logic              pc_we,
    output logic [DW-1:0]     psw_out,
    output logic              psw_we
);
    localparam int PCH_W = PC_W - DW;
    localparam int TGT_W = DW + PAGE_W;

    logic [PC_W-1:0] ret_now, tgt_now, ret_q, tgt_q;
    logic [SP_W-1:0] sp_now, idx_now, idx_q;
    logic [DW-1:0]   psw_q, lo_q;

    // Return address, jump target and frame index for the strobe cycle.
    always_comb begin
        ret_now = pc_cur + PC_W'(2);
        tgt_now = {pc_cur[PC_W-1:TGT_W], page, offset};
        sp_now  = psw_in[SP_W-1:0];
        idx_now = start_push ? sp_now : sp_now - SP_W'(1);
    end

    // Hold the sampled operands and the low popped byte for the second cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '0;
            tgt_q <= '0;
            psw_q <= '0;
            idx_q <= '0;
            lo_q  <= '0;
        end else if (start_push || start_pop) begin
            ret_q <= ret_now;
            tgt_q <= tgt_now;
            psw_q <= psw_in;
            idx_q <= idx_now;
            lo_q  <= ram_rdata;
        end
    end

    // Drive RAM, PC and status outputs for whichever cycle is active.
    always_comb begin
        idx       = (state == ST_IDLE) ? idx_now : idx_q;
        hi_sel    = (state != ST_IDLE);
        ram_we    = start_push || (state == ST_PUSH_HI);
        ram_re    = start_pop || (state == ST_POP_HI);
        ram_wdata = '0;
        pc_out    = '0;
        pc_we     = 1'b0;
        psw_out   = '0;
        psw_we    = 1'b0;
        if (start_push) begin
            ram_wdata = ret_now[DW-1:0];
        end
        case (state)
            ST_PUSH_HI: begin
                ram_wdata = {psw_q[DW-1:PCH_W], ret_q[PC_W-1:DW]};
                pc_out    = tgt_q;
                pc_we     = 1'b1;
                psw_out   = {psw_q[DW-1:SP_W], idx_q + SP_W'(1)};
                psw_we    = 1'b1;
            end
            ST_POP_HI: begin
                pc_out = {ram_rdata[PCH_W-1:0], lo_q};
                pc_we  = 1'b1;
                if (restore_q) begin
                    psw_out = {ram_rdata[DW-1:PCH_W], psw_q[PCH_W-1:SP_W], idx_q};
                end else begin
                    psw_out = {psw_q[DW-1:SP_W], idx_q};
                end
                psw_we = 1'b1;
            end
            default: ;
        endcase
    end

    AST_SP_STEPS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_HI) |-> (psw_out[SP_W-1:0] == SP_W'($past(psw_in[SP_W-1:0]) + 1'b1))); // R4
    AST_SP_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POP_HI) |-> (psw_out[SP_W-1:0] == SP_W'($past(psw_in[SP_W-1:0]) - 1'b1))); // R5
    AST_PLAIN_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_POP_HI) && !restore_q) |-> (psw_out[DW-1:SP_W] == $past(psw_in[DW-1:SP_W]))); // R5
    AST_PC_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> !pc_we); // R8
    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re)); // R2
endmodule

// File: rtl/call_stack_ctrl.sv
// Call/return stack controller top: wires the sequencer, the frame datapath
// and the frame address generator. Assumes a scratch RAM with synchronous
// write and asynchronous read, and one strobe per operation.
module call_stack_ctrl
    import cstk_pkg::*;
#(
    parameter int PC_W       = 12,
    parameter int DW         = 8,
    parameter int SP_W       = 3,
    parameter int PAGE_W     = 3,
    parameter int AW         = 6,
    parameter int STACK_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic              retr_req,
    input  logic [PAGE_W-1:0] call_page,
    input  logic [DW-1:0]     call_offset,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [DW-1:0]     psw_in,
    input  logic [DW-1:0]     ram_rdata,
    output logic [AW-1:0]     ram_addr,
    output logic [DW-1:0]     ram_wdata,
    output logic              ram_we,
    output logic              ram_re,
    output logic [PC_W-1:0]   pc_out,
    output logic              pc_we,
    output logic [DW-1:0]     psw_out,
    output logic              psw_we,
    output logic              busy
);
    localparam int SPAN = 2 ** (SP_W + 1);

    cstk_state_e     state;
    logic            start_push, start_pop, restore_q, hi_sel;
    logic [SP_W-1:0] idx;

    cstk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_call   (call_req),
        .req_ret    (ret_req),
        .req_retr   (retr_req),
        .state      (state),
        .start_push (start_push),
        .start_pop  (start_pop),
        .restore_q  (restore_q)
    );

    cstk_frame #(.PC_W(PC_W), .DW(DW), .SP_W(SP_W), .PAGE_W(PAGE_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .start_push (start_push),
        .start_pop  (start_pop),
        .restore_q  (restore_q),
        .pc_cur     (pc_cur),
        .page       (call_page),
        .offset     (call_offset),
        .psw_in     (psw_in),
        .ram_rdata  (ram_rdata),
        .idx        (idx),
        .hi_sel     (hi_sel),
        .ram_wdata  (ram_wdata),
        .ram_we     (ram_we),
        .ram_re     (ram_re),
        .pc_out     (pc_out),
        .pc_we      (pc_we),
        .psw_out    (psw_out),
        .psw_we     (psw_we)
    );

    cstk_addr #(.SP_W(SP_W), .AW(AW), .STACK_BASE(STACK_BASE)) u_addr (
        .idx    (idx),
        .hi_sel (hi_sel),
        .addr   (ram_addr)
    );

    // Busy flags the second cycle of any operation.
    always_comb busy = (state != ST_IDLE);

    AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |-> ((ram_addr >= AW'(STACK_BASE)) && (ram_addr < AW'(STACK_BASE + SPAN)))); // R2
    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ram_addr == AW'($past(ram_addr) + 1'b1))); // R2
    AST_WE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we || psw_we) |-> busy); // R8
endmodule

// File: tb/call_stack_ctrl_bench.sv
module call_stack_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 0, ret_req = 0, retr_req = 0;
    logic [2:0]  call_page = 0;
    logic [7:0]  call_offset = 0;
    logic [11:0] pc_cur = 0;
    logic [7:0]  psw_in = 0;
    logic [7:0]  ram_rdata;
    logic [5:0]  ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we, ram_re, pc_we, psw_we, busy;
    logic [11:0] pc_out;
    logic [7:0]  psw_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    logic [7:0] mem [64];

    always #10 clk = ~clk;

    call_stack_ctrl u_call_stack_ctrl (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
        .retr_req(retr_req), .call_page(call_page), .call_offset(call_offset),
        .pc_cur(pc_cur), .psw_in(psw_in), .ram_rdata(ram_rdata),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_re(ram_re), .pc_out(pc_out), .pc_we(pc_we), .psw_out(psw_out),
        .psw_we(psw_we), .busy(busy)
    );

    // Scratch RAM model: asynchronous read, write on the rising edge.
    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

    typedef struct packed {
        logic [2:0]  stb;   // {call, restoring return, plain return}
        logic [11:0] pc;
        logic [2:0]  pg;
        logic [7:0]  off;
        logic [7:0]  psw;
        logic [11:0] epc;
        logic [7:0]  epsw;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{3'b100, 12'h123, 3'd5, 8'h40, 8'hA0, 12'h540, 8'hA1},
        '{3'b100, 12'h540, 3'd2, 8'h10, 8'h51, 12'h210, 8'h52},
        '{3'b100, 12'h9FE, 3'd7, 8'hFF, 8'h02, 12'hFFF, 8'h03},
        '{3'b001, 12'h000, 3'd0, 8'h00, 8'hF3, 12'hA00, 8'hF2},
        '{3'b010, 12'h000, 3'd0, 8'h00, 8'h02, 12'h542, 8'h51},
        '{3'b001, 12'h000, 3'd0, 8'h00, 8'h09, 12'h125, 8'h08}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // One operation: strobe cycle checks, then second-cycle checks.
    task automatic run_op(input logic [2:0] stb, input logic [11:0] pc, input logic [2:0] pg,
                          input logic [7:0] off, input logic [7:0] psw,
                          input logic [11:0] epc, input logic [7:0] epsw, input bit poke);
        logic [11:0] ret = pc + 12'd2;
        logic [2:0]  fidx = stb[2] ? psw[2:0] : psw[2:0] - 3'd1;
        logic [5:0]  lo_a = 6'd8 + {2'b00, fidx, 1'b0};
        @(negedge clk);
        {call_req, retr_req, ret_req} = stb;
        pc_cur = pc; call_page = pg; call_offset = off; psw_in = psw;
        #1;
        chk("R8 strobe-cycle busy", busy, 0);
        chk("R8 strobe-cycle pc_we", pc_we, 0);
        chk("R2 low byte address", ram_addr, lo_a);
        if (stb[2]) begin
            chk("R3 low byte write", {ram_we, ram_wdata}, {1'b1, ret[7:0]});
        end else begin
            chk("R9 pop reads, no write", {ram_re, ram_we}, 2'b10);
        end
        @(negedge clk);
        {call_req, retr_req, ret_req} = poke ? 3'b111 : 3'b000;
        pc_cur = 12'hFFF; call_page = 3'd0; call_offset = 8'h00; psw_in = 8'hFF; // R10 junk
        #1;
        chk("R8 second-cycle busy/we", {busy, pc_we, psw_we}, 3'b111);
        chk("R2 high byte address", ram_addr, lo_a + 6'd1);
        if (stb[2]) begin
            chk("R3 high byte write", {ram_we, ram_wdata}, {1'b1, psw[7:4], ret[11:8]});
            chk("R4 call pc_out", pc_out, epc);
            chk("R4 call psw_out", psw_out, epsw);
        end else begin
            chk("R5 R6 return pc_out", pc_out, epc);
            chk("R5 R6 return psw_out", psw_out, epsw);
        end
        @(negedge clk);
        {call_req, retr_req, ret_req} = 3'b000;
        #1;
        chk("R9 R8 idle after operation", {busy, ram_we, ram_re, pc_we, psw_we}, 5'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset idle", {busy, ram_we, ram_re, pc_we, psw_we}, 5'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 idle after release", {busy, ram_we, ram_re, pc_we, psw_we}, 5'b0);

        // Nested calls, then plain, restoring and plain returns (R4 R5 R6).
        for (int i = 0; i < 6; i++) begin
            run_op(VEC[i].stb, VEC[i].pc, VEC[i].pg, VEC[i].off, VEC[i].psw,
                   VEC[i].epc, VEC[i].epsw, 1'b0);
        end
        // Frame layout stays in RAM after the pops (R2 R3).
        chk("R3 frame0 low", mem[8], 8'h25);
        chk("R3 frame0 high", mem[9], 8'hA1);
        chk("R2 frame1 high", mem[11], 8'h55);
        chk("R2 frame2 high", mem[13], 8'h0A);

        // Wrap at pointer 7 and back (R7).
        run_op(3'b100, 12'h000, 3'd0, 8'h00, 8'h37, 12'h000, 8'h30, 1'b0);
        chk("R7 wrap frame low", mem[22], 8'h02);
        chk("R7 wrap frame high", mem[23], 8'h30);
        run_op(3'b010, 12'h000, 3'd0, 8'h00, 8'hC0, 12'h002, 8'h37, 1'b0);

        // Priority and strobes during busy (R9).
        run_op(3'b111, 12'h100, 3'd0, 8'h20, 8'hE0, 12'h020, 8'hE1, 1'b1);
        chk("R9 poke left frame low", mem[8], 8'h02);
        chk("R9 poke left frame high", mem[9], 8'hE1);
        run_op(3'b011, 12'h000, 3'd0, 8'h00, 8'h01, 12'h102, 8'hE0, 1'b0);

        done = 1;
        summary();
        $finish;
    end
endmodule